// File: doc/BRIEF.md
# Oversampled Serial Receiver with Holding Buffer and Sticky Error Flags

This block receives asynchronous serial characters (one low start bit, data least significant bit first, an optional parity bit, one high stop bit) on a line that it samples at each pulse of an external oversampling tick. The tick runs at a fixed multiple of the bit rate. A loopback select can take the line from the local transmit output in place of the external pin, so the receive path can be tested without outside wiring.

Each finished character goes from the shift stage into a 16-bit receive buffer, and a one-clock interrupt pulse is raised. The shift stage can take in the next character while the buffer still holds an unread one. The host reads the buffer and gives a read strobe. Parity, framing and overrun faults each have an enable and a sticky flag. Only an explicit clear strobe resets a flag.

Top module: `uart_rx_dbuf`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle, no character is accepted, and `rx_irq`, `rbuf` and the flags do not change because of line activity.
- R2: A falling edge starts a character only if a majority of three line samples, taken at oversample ticks OVERSAMPLE/2-1, OVERSAMPLE/2 and OVERSAMPLE/2+1 of the start bit, is low. Otherwise the edge is dropped as a glitch and no character is produced. Data and stop bits use the same three-sample vote.
- R3: `mode` sets the layout of the frame and of `rbuf`, with bits received least significant first. The encodings are:
  - 00: 8 data bits in `rbuf[7:0]`.
  - 01: 7 data bits in `rbuf[6:0]`, with the parity bit in `rbuf[7]`.
  - 10: 8 data bits in `rbuf[7:0]`, with the parity bit in `rbuf[8]`.
  - 11: 9 data bits in `rbuf[8:0]`.
  
  Every `rbuf` bit above the bits the mode uses reads 0.
- R4: With `par_odd`=0 the parity is even: the expected parity bit is 1 when the data holds an odd number of ones. With `par_odd`=1 the parity is odd.
- R5: `pe_flag` is set when a character with wrong parity completes in a parity mode while `pe_en`=1. It is never set while `pe_en`=0. It stays set until a `clr_pe` pulse clears it.
- R6: `fe_flag` is set when the stop bit is voted low while `fe_en`=1. It is never set while `fe_en`=0. It stays set until a `clr_fe` pulse clears it.
- R7: When a character completes while the buffer holds a character that has not been read, `oe_flag` is set if `oe_en`=1. It stays set until a `clr_oe` pulse clears it. In either case the new character overwrites `rbuf`.
- R8: `rx_irq` is high for exactly one clock each time `rbuf` is loaded, in the same cycle that the new value appears on `rbuf`.
- R9: With `loop_sel`=1 the receiver takes its line from `tx_loop` and ignores `rx_pin`. With `loop_sel`=0 it takes `rx_pin` and ignores `tx_loop`.
- R10: The buffer is double-buffered. A `rd_strobe` marks the buffered character as read, so a following character loads without an overrun. The shift stage keeps receiving while the buffer is unread.
- R11: After reset `rbuf` is 0 and all three flags and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick pulse, OVERSAMPLE per bit |
| rx_pin | input | 1 | External serial input |
| tx_loop | input | 1 | Local transmit output, used in loopback |
| rx_en | input | 1 | Receiver enable |
| mode | input | 2 | Frame layout select (see R3) |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| loop_sel | input | 1 | 1 = receive from tx_loop |
| pe_en | input | 1 | Parity error detection enable |
| fe_en | input | 1 | Framing error detection enable |
| oe_en | input | 1 | Overrun detection enable |
| rd_strobe | input | 1 | Buffer read strobe |
| clr_pe | input | 1 | Clear strobe for pe_flag |
| clr_fe | input | 1 | Clear strobe for fe_flag |
| clr_oe | input | 1 | Clear strobe for oe_flag |
| rbuf | output | 16 | Receive buffer, unused upper bits zero |
| pe_flag | output | 1 | Sticky parity error flag |
| fe_flag | output | 1 | Sticky framing error flag |
| oe_flag | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | One-clock receive-complete pulse |

## Verification
The bench builds the block with its default parameters: OVERSAMPLE=16, SYNC_STAGES=2 and BUF_W=16. It drives one oversample tick every four clocks, so a bit lasts 64 clocks. This puts the three-sample vote well inside each bit even after the synchronizer delay and the tick phase. It also lets a three-tick low pulse stand as a clean glitch that the start vote must reject. The 16-bit buffer above a 9-bit frame lets the bench check the zero fill of the upper seven bits in every mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int FRAME_MAX = 9;

    typedef enum logic [1:0] {
        MODE_D8  = 2'b00,
        MODE_D7P = 2'b01,
        MODE_D8P = 2'b10,
        MODE_D9  = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    function automatic logic [3:0] frame_bits(rx_mode_e m);
        return (m == MODE_D8 || m == MODE_D7P) ? 4'd8 : 4'd9;
    endfunction

    function automatic logic has_parity(rx_mode_e m);
        return (m == MODE_D7P) || (m == MODE_D8P);
    endfunction

    function automatic logic vote3(logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic tx_loop,
    input  logic loop_sel,
    output logic line
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   raw;

    always_comb begin
        raw    = loop_sel ? tx_loop : rx_pin;
        sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rx_en,
    input  logic                 line,
    input  rx_mode_e             mode,
    output logic                 done,
    output logic [FRAME_MAX-1:0] frame,
    output logic                 stop_ok
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] S_LO  = CW'(OVERSAMPLE/2 - 1);
    localparam logic [CW-1:0] S_MID = CW'(OVERSAMPLE/2);
    localparam logic [CW-1:0] S_HI  = CW'(OVERSAMPLE/2 + 1);
    localparam logic [CW-1:0] S_END = CW'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        tick;
        logic [3:0]           bitn;
        logic [2:0]           vote;
        logic [FRAME_MAX-1:0] shreg;
        logic                 done;
        logic                 stop_ok;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [CW-1:0] cur;
    logic [2:0]    nv;
    logic          in_win;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cur      = (r_q.tick == S_END) ? '0 : r_q.tick + 1'b1;
        in_win   = (cur == S_LO) || (cur == S_MID) || (cur == S_HI);
        nv       = {r_q.vote[1:0], line};
        if (!rx_en) begin
            r_d.state = ST_IDLE;
            r_d.tick  = '0;
        end else if (os_tick) begin
            if (r_q.state == ST_IDLE) begin
                if (!line) begin
                    r_d.state = ST_START;
                    r_d.tick  = '0;
                    r_d.bitn  = '0;
                    r_d.shreg = '0;
                end
            end else begin
                r_d.tick = cur;
                if (in_win) r_d.vote = nv;
                case (r_q.state)
                    ST_START: if (cur == S_END)
                        r_d.state = vote3(r_q.vote) ? ST_IDLE : ST_DATA;
                    ST_DATA: if (cur == S_END) begin
                        r_d.shreg[r_q.bitn] = vote3(r_q.vote);
                        r_d.bitn            = r_q.bitn + 4'd1;
                        if (r_q.bitn + 4'd1 == frame_bits(mode))
                            r_d.state = ST_STOP;
                    end
                    ST_STOP: if (cur == S_HI) begin
                        r_d.done    = 1'b1;
                        r_d.stop_ok = vote3(nv);
                        r_d.state   = ST_IDLE;
                    end
                    default: r_d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, tick: '0, bitn: '0, vote: '1,
                             shreg: '0, done: 1'b0, stop_ok: 1'b1};
        else        r_q <= r_d;
    end

    assign done    = r_q.done;
    assign frame   = r_q.shreg;
    assign stop_ok = r_q.stop_ok;

    AST_NO_DONE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !done); // R1
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> r_q.state == ST_IDLE); // R2

endmodule

// File: rtl/rx_buffer_flags.sv
module rx_buffer_flags
    import uart_rx_pkg::*;
#(
    parameter int BUF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [FRAME_MAX-1:0] frame,
    input  logic                 stop_ok,
    input  rx_mode_e             mode,
    input  logic                 par_odd,
    input  logic                 pe_en,
    input  logic                 fe_en,
    input  logic                 oe_en,
    input  logic                 rd_strobe,
    input  logic                 clr_pe,
    input  logic                 clr_fe,
    input  logic                 clr_oe,
    output logic [BUF_W-1:0]     rbuf,
    output logic                 pe_flag,
    output logic                 fe_flag,
    output logic                 oe_flag,
    output logic                 rx_irq
);
    typedef struct packed {
        logic [BUF_W-1:0] rbuf;
        logic             full;
        logic             pe;
        logic             fe;
        logic             oe;
        logic             irq;
    } buf_t;

    buf_t b_d, b_q;
    logic par_bad;

    always_comb begin
        b_d     = b_q;
        b_d.irq = done;
        par_bad = has_parity(mode) && ((^frame) != par_odd);
        if (rd_strobe) b_d.full = 1'b0;
        if (clr_pe)    b_d.pe   = 1'b0;
        if (clr_fe)    b_d.fe   = 1'b0;
        if (clr_oe)    b_d.oe   = 1'b0;
        if (done) begin
            b_d.rbuf = BUF_W'(frame);
            b_d.full = 1'b1;
            if (pe_en && par_bad)                  b_d.pe = 1'b1;
            if (fe_en && !stop_ok)                 b_d.fe = 1'b1;
            if (oe_en && b_q.full && !rd_strobe)   b_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign rbuf    = b_q.rbuf;
    assign pe_flag = b_q.pe;
    assign fe_flag = b_q.fe;
    assign oe_flag = b_q.oe;
    assign rx_irq  = b_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R8
    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pe_flag && !clr_pe |=> pe_flag); // R5
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fe_flag && !clr_fe |=> fe_flag); // R6
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_flag && !oe_en |=> !oe_flag); // R7
    AST_RBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rbuf)); // R10

    generate
        if (BUF_W > FRAME_MAX) begin : g_zero_top
            AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                rbuf[BUF_W-1:FRAME_MAX] == '0); // R3
        end
    endgenerate

endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rx_pin,
    input  logic             tx_loop,
    input  logic             rx_en,
    input  logic [1:0]       mode,
    input  logic             par_odd,
    input  logic             loop_sel,
    input  logic             pe_en,
    input  logic             fe_en,
    input  logic             oe_en,
    input  logic             rd_strobe,
    input  logic             clr_pe,
    input  logic             clr_fe,
    input  logic             clr_oe,
    output logic [BUF_W-1:0] rbuf,
    output logic             pe_flag,
    output logic             fe_flag,
    output logic             oe_flag,
    output logic             rx_irq
);
    logic                 line;
    logic                 done;
    logic                 stop_ok;
    logic [FRAME_MAX-1:0] frame;
    rx_mode_e             mode_e;

    assign mode_e = rx_mode_e'(mode);

    rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_sel(loop_sel), .line(line)
    );

    rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .line(line), .mode(mode_e), .done(done), .frame(frame),
        .stop_ok(stop_ok)
    );

    rx_buffer_flags #(.BUF_W(BUF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .done(done), .frame(frame),
        .stop_ok(stop_ok), .mode(mode_e), .par_odd(par_odd),
        .pe_en(pe_en), .fe_en(fe_en), .oe_en(oe_en),
        .rd_strobe(rd_strobe), .clr_pe(clr_pe), .clr_fe(clr_fe),
        .clr_oe(clr_oe), .rbuf(rbuf), .pe_flag(pe_flag),
        .fe_flag(fe_flag), .oe_flag(oe_flag), .rx_irq(rx_irq)
    );

endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
    localparam int OS       = 16;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = OS * TICK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_pin = 1'b1, tx_loop = 1'b1;
    logic rx_en = 1'b0, par_odd = 1'b0, loop_sel = 1'b0;
    logic [1:0] mode = 2'b00;
    logic pe_en = 1'b0, fe_en = 1'b0, oe_en = 1'b0;
    logic rd_strobe = 1'b0, clr_pe = 1'b0, clr_fe = 1'b0, clr_oe = 1'b0;
    logic [15:0] rbuf;
    logic pe_flag, fe_flag, oe_flag, rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [15:0] rb;
        logic        pe;
        logic        fe;
        logic        oe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic  m_pe = 0, m_fe = 0, m_oe = 0, m_full = 0;
    logic [15:0] m_rbuf = '0;

    uart_rx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .tx_loop(tx_loop), .rx_en(rx_en), .mode(mode), .par_odd(par_odd),
        .loop_sel(loop_sel), .pe_en(pe_en), .fe_en(fe_en), .oe_en(oe_en),
        .rd_strobe(rd_strobe), .clr_pe(clr_pe), .clr_fe(clr_fe),
        .clr_oe(clr_oe), .rbuf(rbuf), .pe_flag(pe_flag), .fe_flag(fe_flag),
        .oe_flag(oe_flag), .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every receive pulse
    initial begin
        logic prev_irq;
        prev_irq = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_irq && prev_irq)
                check(0, "R8", "irq wider than one clock", 32'd2, 32'd1);
            if (rx_irq) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected irq, rbuf", 32'(rbuf), 32'(m_rbuf));
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rbuf == e.rb, t, "rbuf", 32'(rbuf), 32'(e.rb));
                    check({pe_flag, fe_flag, oe_flag} == {e.pe, e.fe, e.oe}, t,
                          "flags pe/fe/oe", 32'({pe_flag, fe_flag, oe_flag}),
                          32'({e.pe, e.fe, e.oe}));
                end
            end
            prev_irq = rx_irq;
        end
    end

    task automatic drive_bit(input bit on_loop, input logic v);
        if (on_loop) tx_loop = v;
        else         rx_pin  = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] md, input logic [8:0] dat,
                              input bit bad_par, input bit bad_stop,
                              input bit on_loop, input string tag);
        logic [8:0] bits;
        logic       p;
        int         nb;
        bit         accept;
        mode = md;
        case (md)
            2'b00: begin bits = {1'b0, dat[7:0]}; nb = 8; end
            2'b01: begin
                p = (^dat[6:0]) ^ par_odd ^ bad_par;
                bits = {1'b0, p, dat[6:0]}; nb = 8;
            end
            2'b10: begin
                p = (^dat[7:0]) ^ par_odd ^ bad_par;
                bits = {p, dat[7:0]}; nb = 9;
            end
            default: begin bits = dat; nb = 9; end
        endcase
        accept = rx_en && (on_loop == loop_sel);
        if (accept) begin
            exp_t e;
            if (pe_en && bad_par && (md == 2'b01 || md == 2'b10)) m_pe = 1'b1;
            if (fe_en && bad_stop) m_fe = 1'b1;
            if (oe_en && m_full)   m_oe = 1'b1;
            m_full = 1'b1;
            m_rbuf = {7'd0, bits};
            e.rb = m_rbuf; e.pe = m_pe; e.fe = m_fe; e.oe = m_oe;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        drive_bit(on_loop, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(on_loop, bits[i]);
        drive_bit(on_loop, !bad_stop);
        drive_bit(on_loop, 1'b1);
        drive_bit(on_loop, 1'b1);
        check(exp_q.size() == 0, tag, "pending scoreboard items",
              32'(exp_q.size()), 32'd0);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        m_full = 1'b0;
    endtask

    task automatic pulse_clr(input int which);
        if (which == 0) clr_pe = 1'b1;
        if (which == 1) clr_fe = 1'b1;
        if (which == 2) clr_oe = 1'b1;
        @(negedge clk);
        clr_pe = 1'b0; clr_fe = 1'b0; clr_oe = 1'b0;
        @(negedge clk);
        if (which == 0) m_pe = 1'b0;
        if (which == 1) m_fe = 1'b0;
        if (which == 2) m_oe = 1'b0;
    endtask

    task automatic check_flags(input string req);
        check({pe_flag, fe_flag, oe_flag} == {m_pe, m_fe, m_oe}, req,
              "flags at port", 32'({pe_flag, fe_flag, oe_flag}),
              32'({m_pe, m_fe, m_oe}));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        check(rbuf == 16'h0, "R11", "rbuf after reset", 32'(rbuf), 32'h0);
        check({pe_flag, fe_flag, oe_flag, rx_irq} == 4'b0, "R11",
              "flags/irq after reset", 32'({pe_flag, fe_flag, oe_flag, rx_irq}), 32'h0);

        rx_en = 1'b1; pe_en = 1'b1; fe_en = 1'b1; oe_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R3 R8 modes and layouts
        send_frame(2'b00, 9'h0A5, 0, 0, 0, "R3 8-bit");            do_read();
        send_frame(2'b01, 9'h035, 0, 0, 0, "R3 R4 7+P even p0");  do_read();
        send_frame(2'b01, 9'h007, 0, 0, 0, "R3 R4 7+P even p1");  do_read();
        par_odd = 1'b1;
        send_frame(2'b01, 9'h007, 0, 0, 0, "R4 7+P odd");         do_read();
        send_frame(2'b10, 9'h0FF, 0, 0, 0, "R3 R4 8+P odd");      do_read();
        par_odd = 1'b0;
        send_frame(2'b10, 9'h001, 0, 0, 0, "R3 R4 8+P even");     do_read();
        send_frame(2'b11, 9'h155, 0, 0, 0, "R3 9-bit");           do_read();
        check_flags("R4 no error flags on good parity");

        // R5 parity error, sticky, clear, disabled
        send_frame(2'b10, 9'h03C, 1, 0, 0, "R5 bad parity");      do_read();
        send_frame(2'b00, 9'h011, 0, 0, 0, "R5 sticky pe");       do_read();
        pulse_clr(0);
        check_flags("R5 pe cleared");
        pe_en = 1'b0;
        send_frame(2'b01, 9'h05A, 1, 0, 0, "R5 pe disabled");     do_read();
        check_flags("R5 pe stays clear when disabled");
        pe_en = 1'b1;

        // R6 framing error
        send_frame(2'b00, 9'h0C3, 0, 1, 0, "R6 bad stop");        do_read();
        check_flags("R6 fe set");
        pulse_clr(1);
        check_flags("R6 fe cleared");
        fe_en = 1'b0;
        send_frame(2'b00, 9'h03C, 0, 1, 0, "R6 fe disabled");     do_read();
        check_flags("R6 fe stays clear when disabled");
        fe_en = 1'b1;

        // R10 read between characters avoids overrun
        send_frame(2'b00, 9'h012, 0, 0, 0, "R10 first");          do_read();
        send_frame(2'b00, 9'h034, 0, 0, 0, "R10 second after read");
        check_flags("R10 no overrun after read");
        // R7 overrun: second character without read
        send_frame(2'b00, 9'h056, 0, 0, 0, "R7 overrun overwrite");
        check(rbuf == 16'h0056, "R7", "rbuf overwritten", 32'(rbuf), 32'h56);
        pulse_clr(2);
        check_flags("R7 oe cleared");
        do_read();
        oe_en = 1'b0;
        send_frame(2'b00, 9'h078, 0, 0, 0, "R7 oe disabled a");
        send_frame(2'b00, 9'h09A, 0, 0, 0, "R7 oe disabled b");
        check_flags("R7 oe stays clear when disabled");
        do_read();
        oe_en = 1'b1;

        // R2 glitch rejection
        rx_pin = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_pin = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check(rbuf == m_rbuf, "R2", "rbuf after glitch", 32'(rbuf), 32'(m_rbuf));
        check(exp_q.size() == 0, "R2", "no pending items", 32'(exp_q.size()), 32'd0);
        send_frame(2'b00, 9'h0E7, 0, 0, 0, "R2 frame after glitch"); do_read();

        // R1 receiver disabled
        rx_en = 1'b0;
        send_frame(2'b00, 9'h0AA, 0, 0, 0, "R1 disabled");
        check(rbuf == m_rbuf, "R1", "rbuf unchanged while disabled", 32'(rbuf), 32'(m_rbuf));
        rx_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        send_frame(2'b00, 9'h055, 0, 0, 0, "R1 re-enabled");      do_read();

        // R9 loopback
        loop_sel = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        send_frame(2'b11, 9'h1C6, 0, 0, 1, "R9 loopback");        do_read();
        send_frame(2'b00, 9'h0F0, 0, 0, 0, "R9 pin ignored");
        check(rbuf == 16'h01C6, "R9", "rbuf unchanged by pin", 32'(rbuf), 32'h1C6);
        loop_sel = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        send_frame(2'b00, 9'h0F0, 0, 0, 1, "R9 loop ignored");
        check(rbuf == 16'h01C6, "R9", "rbuf unchanged by tx_loop", 32'(rbuf), 32'h1C6);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule